// File: doc/BRIEF.md
# Private-cache MSI line coherence controller

This block runs the coherence state machine for a single line of a private first-level cache that talks to a directory. It accepts load, store and eviction requests from the core, sends GetS, GetM and PutM requests to the directory, and answers forwarded requests and invalidations with data or invalidation acknowledgements. It also consumes data and acknowledgement responses. The line moves through the stable states I, S and M. While a request is outstanding it sits in one of several transient states.

Invalidation acknowledgements from peer caches can arrive before the directory's data message. That message carries the number of acknowledgements to expect. The controller keeps a signed counter that may go negative and adds the directory's count when the data arrives. It decides completion on the updated value. Three input channels (response, forward, core) are arbitrated to one event per cycle. All outputs are registered, so every effect appears one clock after the event is accepted.

Top module: `msi_line_ctrl`

## Requirements
- R1: A load (core_op 0) in I sends GetS (dir_req_type 0) and enters IS_D (line_state 3). Directory data (rin_type 0, any ack count) or owner data (rin_type 1) then moves the line to S (line_state 1) and pulses load_done.
- R2: A store (core_op 1) sends GetM (dir_req_type 1). From S it enters SM_AD (line_state 6) and from I it enters IM_AD (line_state 4). In both cases the ack counter is cleared.
- R3: Directory data whose ack count leaves the counter nonzero moves SM_AD to SM_A (7) or IM_AD to IM_A (5) without completing the store. The InvAck (rin_type 2) that brings the counter to zero moves the line to M (line_state 2) and pulses store_done.
- R4: The ack counter is signed. Each InvAck received before the data decrements it, even below zero, and the directory's count is added when its data arrives. If that sum is zero the line goes straight to M with store_done.
- R5: A load in S or M, or a store in M, pulses the matching done output without any directory request and without a state change.
- R6: An eviction (core_op 2) in M sends PutM (dir_req_type 2) and enters MI_A (8). A PutAck arriving on the forward channel (fwd_type 1) moves the line to I.
- R7: An invalidation (fwd_type 0) in S moves the line to I and sends an InvAck (rout_type 1) whose destination is the fwd_src of the invalidation.
- R8: An invalidation in SM_AD is legal. It sends an InvAck to fwd_src and moves the line to IM_AD, and a later store completion then reaches M.
- R9: In any transient state, every core request, evictions included, is stalled: core_ready is low, and there is no state change and no request. An eviction in S drops silently to I, and an eviction in I has no effect.
- R10: A forwarded GetS (fwd_type 2) in M sends Data (rout_type 0) to fwd_src and moves the line to S. A forwarded GetM (fwd_type 3) in M does the same but moves the line to I.
- R11: Any event with no defined transition for the current state pulses proto_err, leaves the state unchanged and sends no message.
- R12: Only one event is taken per cycle. The response channel wins over the forward channel, and the forward channel wins over the core. A core request that loses sees core_ready low and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 0 load, 1 store, 2 evict |
| core_ready | output | 1 | Core request accepted this cycle |
| load_done | output | 1 | Load completion pulse |
| store_done | output | 1 | Store completion pulse |
| dir_req_valid | output | 1 | Request to directory |
| dir_req_type | output | 2 | 0 GetS, 1 GetM, 2 PutM |
| fwd_valid | input | 1 | Forward-channel message present |
| fwd_type | input | 2 | 0 Inv, 1 PutAck, 2 FwdGetS, 3 FwdGetM |
| fwd_src | input | NODE_W | Original requestor of the forwarded message |
| fwd_ready | output | 1 | Forward message accepted this cycle |
| rin_valid | input | 1 | Response-channel message present |
| rin_type | input | 2 | 0 directory data, 1 owner data, 2 InvAck |
| rin_acks | input | ACK_W | Ack count carried by directory data |
| rout_valid | output | 1 | Outgoing response |
| rout_type | output | 1 | 0 Data, 1 InvAck |
| rout_dest | output | NODE_W | Destination of the outgoing response |
| line_state | output | 4 | Current state code |
| proto_err | output | 1 | Undefined-transition pulse |

## Verification
The store path is driven with three arrival orders: data carrying a zero count, data carrying a count that is then paid off by later InvAcks, and an InvAck that arrives before the data so the counter goes negative. These orders separate a correct post-update completion decision from one that looks at the old counter value or forbids negative values. Forwarded messages are applied in S, M, SM_AD and I. This shows the difference between legal races, such as an invalidation during an upgrade, and true protocol errors. Evictions are issued in I, S, M and transient states, and a forward message and a core request are offered together, to check stalling and the arbitration order.

// File: rtl/msi_line_pkg.sv
package msi_line_pkg;

    typedef enum logic [3:0] {
        ST_I     = 4'd0,
        ST_S     = 4'd1,
        ST_M     = 4'd2,
        ST_IS_D  = 4'd3,
        ST_IM_AD = 4'd4,
        ST_IM_A  = 4'd5,
        ST_SM_AD = 4'd6,
        ST_SM_A  = 4'd7,
        ST_MI_A  = 4'd8,
        ST_SI_A  = 4'd9,
        ST_II_A  = 4'd10
    } line_st_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_LOAD,
        EV_STORE,
        EV_EVICT,
        EV_INV,
        EV_PUTACK,
        EV_FWD_GETS,
        EV_FWD_GETM,
        EV_DATA_DIR,
        EV_DATA_OWN,
        EV_INVACK,
        EV_BAD
    } line_ev_e;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_EVICT = 2'd2;

    localparam logic [1:0] FWD_INV    = 2'd0;
    localparam logic [1:0] FWD_PUTACK = 2'd1;
    localparam logic [1:0] FWD_GETS   = 2'd2;
    localparam logic [1:0] FWD_GETM   = 2'd3;

    localparam logic [1:0] RIN_DATA_DIR = 2'd0;
    localparam logic [1:0] RIN_DATA_OWN = 2'd1;
    localparam logic [1:0] RIN_INVACK   = 2'd2;

    localparam logic [1:0] REQ_GETS = 2'd0;
    localparam logic [1:0] REQ_GETM = 2'd1;
    localparam logic [1:0] REQ_PUTM = 2'd2;

    localparam logic ROUT_DATA   = 1'b0;
    localparam logic ROUT_INVACK = 1'b1;

    function automatic logic is_transient(line_st_e s);
        return (s != ST_I) && (s != ST_S) && (s != ST_M);
    endfunction

endpackage

// File: rtl/msi_line_evsel.sv
module msi_line_evsel
    import msi_line_pkg::*;
(
    input  line_st_e   state,
    input  logic       core_valid,
    input  logic [1:0] core_op,
    input  logic       fwd_valid,
    input  logic [1:0] fwd_type,
    input  logic       rin_valid,
    input  logic [1:0] rin_type,
    output line_ev_e   ev,
    output logic       core_ready,
    output logic       fwd_ready
);

    always_comb begin
        ev         = EV_NONE;
        core_ready = 1'b0;
        fwd_ready  = 1'b0;
        if (rin_valid) begin
            unique case (rin_type)
                RIN_DATA_DIR: ev = EV_DATA_DIR;
                RIN_DATA_OWN: ev = EV_DATA_OWN;
                RIN_INVACK:   ev = EV_INVACK;
                default:      ev = EV_BAD;
            endcase
        end else begin
            // an invalidation racing a pending read waits for the data
            fwd_ready  = !((state == ST_IS_D) && (fwd_type == FWD_INV));
            core_ready = !fwd_valid && !is_transient(state);
            if (fwd_valid && fwd_ready) begin
                unique case (fwd_type)
                    FWD_INV:    ev = EV_INV;
                    FWD_PUTACK: ev = EV_PUTACK;
                    FWD_GETS:   ev = EV_FWD_GETS;
                    default:    ev = EV_FWD_GETM;
                endcase
            end else if (core_valid && core_ready) begin
                unique case (core_op)
                    OP_LOAD:  ev = EV_LOAD;
                    OP_STORE: ev = EV_STORE;
                    OP_EVICT: ev = EV_EVICT;
                    default:  ev = EV_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/msi_ack_ctr.sv
module msi_ack_ctr #(
    parameter int ADD_W  = 4,
    parameter int MAX_V  = 15,
    localparam int CNT_W = ADD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    add_en,
    input  logic [ADD_W-1:0]        add_val,
    input  logic                    dec_en,
    output logic signed [CNT_W-1:0] cnt_q,
    output logic signed [CNT_W-1:0] cnt_sum
);

    logic signed [CNT_W-1:0] cnt_d;
    logic signed [CNT_W-1:0] add_ext;

    always_comb begin
        add_ext = add_en ? $signed({{(CNT_W-ADD_W){1'b0}}, add_val}) : '0;
        cnt_sum = cnt_q + add_ext - (dec_en ? CNT_W'(1) : CNT_W'(0));
        cnt_d   = clr ? '0 : cnt_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the counter stays within the peer population either side of zero
    a_r4_ctr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) <= MAX_V) && (int'(cnt_q) >= -MAX_V));

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_line_pkg::*;
#(
    parameter int NODE_W      = 4,
    parameter int MAX_SHARERS = 15,
    localparam int ACK_W      = $clog2(MAX_SHARERS + 1),
    localparam int CNT_W      = ACK_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [1:0]        core_op,
    output logic              core_ready,
    output logic              load_done,
    output logic              store_done,
    output logic              dir_req_valid,
    output logic [1:0]        dir_req_type,
    input  logic              fwd_valid,
    input  logic [1:0]        fwd_type,
    input  logic [NODE_W-1:0] fwd_src,
    output logic              fwd_ready,
    input  logic              rin_valid,
    input  logic [1:0]        rin_type,
    input  logic [ACK_W-1:0]  rin_acks,
    output logic              rout_valid,
    output logic              rout_type,
    output logic [NODE_W-1:0] rout_dest,
    output logic [3:0]        line_state,
    output logic              proto_err
);

    typedef struct packed {
        line_st_e          st;
        logic              ld_done;
        logic              st_done;
        logic              err;
        logic              req_v;
        logic [1:0]        req_t;
        logic              rout_v;
        logic              rout_t;
        logic [NODE_W-1:0] rout_dst;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    line_ev_e ev;
    logic     ctr_clr, ctr_add, ctr_dec, bad;
    logic [ACK_W-1:0]        ctr_val;
    logic signed [CNT_W-1:0] ctr_q, ctr_sum;

    msi_line_evsel u_evsel (
        .state      (ctl_q.st),
        .core_valid (core_valid),
        .core_op    (core_op),
        .fwd_valid  (fwd_valid),
        .fwd_type   (fwd_type),
        .rin_valid  (rin_valid),
        .rin_type   (rin_type),
        .ev         (ev),
        .core_ready (core_ready),
        .fwd_ready  (fwd_ready)
    );

    msi_ack_ctr #(
        .ADD_W (ACK_W),
        .MAX_V (MAX_SHARERS)
    ) u_ack_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .add_en  (ctr_add),
        .add_val (ctr_val),
        .dec_en  (ctr_dec),
        .cnt_q   (ctr_q),
        .cnt_sum (ctr_sum)
    );

    // owner data never carries a count
    assign ctr_val = (ev == EV_DATA_DIR) ? rin_acks : '0;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ld_done = 1'b0;
        ctl_d.st_done = 1'b0;
        ctl_d.err     = 1'b0;
        ctl_d.req_v   = 1'b0;
        ctl_d.rout_v  = 1'b0;
        ctr_clr       = 1'b0;
        ctr_add       = 1'b0;
        ctr_dec       = 1'b0;
        bad           = 1'b0;

        case (ev)
            EV_NONE: ;
            EV_LOAD: begin
                case (ctl_q.st)
                    ST_I: begin
                        ctl_d.req_v = 1'b1;
                        ctl_d.req_t = REQ_GETS;
                        ctl_d.st    = ST_IS_D;
                    end
                    ST_S, ST_M: ctl_d.ld_done = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
            EV_STORE: begin
                case (ctl_q.st)
                    ST_I, ST_S: begin
                        ctl_d.req_v = 1'b1;
                        ctl_d.req_t = REQ_GETM;
                        ctl_d.st    = (ctl_q.st == ST_I) ? ST_IM_AD : ST_SM_AD;
                        ctr_clr     = 1'b1;
                    end
                    ST_M: ctl_d.st_done = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
            EV_EVICT: begin
                case (ctl_q.st)
                    ST_I: ;
                    ST_S: ctl_d.st = ST_I;
                    ST_M: begin
                        ctl_d.req_v = 1'b1;
                        ctl_d.req_t = REQ_PUTM;
                        ctl_d.st    = ST_MI_A;
                    end
                    default: bad = 1'b1;
                endcase
            end
            EV_INV: begin
                case (ctl_q.st)
                    ST_S, ST_SM_AD, ST_SI_A: begin
                        ctl_d.rout_v   = 1'b1;
                        ctl_d.rout_t   = ROUT_INVACK;
                        ctl_d.rout_dst = fwd_src;
                        ctl_d.st       = (ctl_q.st == ST_S)     ? ST_I :
                                         (ctl_q.st == ST_SM_AD) ? ST_IM_AD : ST_II_A;
                    end
                    default: bad = 1'b1;
                endcase
            end
            EV_PUTACK: begin
                case (ctl_q.st)
                    ST_MI_A, ST_SI_A, ST_II_A: ctl_d.st = ST_I;
                    default: bad = 1'b1;
                endcase
            end
            EV_FWD_GETS, EV_FWD_GETM: begin
                case (ctl_q.st)
                    ST_M, ST_MI_A: begin
                        ctl_d.rout_v   = 1'b1;
                        ctl_d.rout_t   = ROUT_DATA;
                        ctl_d.rout_dst = fwd_src;
                        if (ctl_q.st == ST_M)
                            ctl_d.st = (ev == EV_FWD_GETS) ? ST_S : ST_I;
                        else
                            ctl_d.st = (ev == EV_FWD_GETS) ? ST_SI_A : ST_II_A;
                    end
                    default: bad = 1'b1;
                endcase
            end
            EV_DATA_DIR, EV_DATA_OWN: begin
                case (ctl_q.st)
                    ST_IS_D: begin
                        ctl_d.st      = ST_S;
                        ctl_d.ld_done = 1'b1;
                    end
                    ST_IM_AD, ST_SM_AD: begin
                        ctr_add = 1'b1;
                        if (ctr_sum == '0) begin
                            ctl_d.st      = ST_M;
                            ctl_d.st_done = 1'b1;
                        end else begin
                            ctl_d.st = (ctl_q.st == ST_IM_AD) ? ST_IM_A : ST_SM_A;
                        end
                    end
                    default: bad = 1'b1;
                endcase
            end
            EV_INVACK: begin
                case (ctl_q.st)
                    ST_IM_AD, ST_SM_AD: ctr_dec = 1'b1;
                    ST_IM_A, ST_SM_A: begin
                        ctr_dec = 1'b1;
                        if (ctr_sum == '0) begin
                            ctl_d.st      = ST_M;
                            ctl_d.st_done = 1'b1;
                        end
                    end
                    default: bad = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase

        if (bad) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_I, req_t: '0, rout_dst: '0, default: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_done     = ctl_q.ld_done;
    assign store_done    = ctl_q.st_done;
    assign dir_req_valid = ctl_q.req_v;
    assign dir_req_type  = ctl_q.req_t;
    assign rout_valid    = ctl_q.rout_v;
    assign rout_type     = ctl_q.rout_t;
    assign rout_dest     = ctl_q.rout_dst;
    assign line_state    = ctl_q.st;
    assign proto_err     = ctl_q.err;

    // R1: a GetS is only ever issued together with the entry into IS_D
    a_r1_gets_enters_isd: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_req_valid && dir_req_type == REQ_GETS) |-> (line_state == ST_IS_D));

    // R3 / R4: once in M the outstanding-ack counter has settled at zero
    a_r4_m_counter_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == ST_M) |-> (ctr_q == '0));

    // R6: a PutAck accepted in MI_A lands in I
    a_r6_putack_to_i: assert property (@(posedge clk) disable iff (!rst_n)
        (!rin_valid && fwd_valid && fwd_type == FWD_PUTACK && line_state == ST_MI_A)
        |=> (line_state == ST_I));

    // R7: every InvAck goes back to the node named in the invalidation
    a_r7_invack_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rout_valid && rout_type == ROUT_INVACK) |-> (rout_dest == $past(fwd_src)));

    // R9: core requests in transient states are refused and change nothing
    a_r9_transient_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !rin_valid && !fwd_valid && is_transient(line_st_e'(line_state)))
        |-> !core_ready);
    a_r9_stall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !rin_valid && !fwd_valid && is_transient(line_st_e'(line_state)))
        |=> (line_state == $past(line_state)));

    // R11: an error pulse comes with an unchanged state and no message
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (line_state == $past(line_state)) && !dir_req_valid && !rout_valid);

    // R12: at most one completion-or-error indication per cycle
    a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_done, store_done, proto_err}));

endmodule

// File: tb/msi_line_ctrl_bench.sv
`timescale 1ns/1ps
module msi_line_ctrl_bench;

    localparam int NODE_W = 4;
    localparam int ACK_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              core_valid;
    logic [1:0]        core_op;
    logic              core_ready;
    logic              load_done, store_done;
    logic              dir_req_valid;
    logic [1:0]        dir_req_type;
    logic              fwd_valid;
    logic [1:0]        fwd_type;
    logic [NODE_W-1:0] fwd_src;
    logic              fwd_ready;
    logic              rin_valid;
    logic [1:0]        rin_type;
    logic [ACK_W-1:0]  rin_acks;
    logic              rout_valid;
    logic              rout_type;
    logic [NODE_W-1:0] rout_dest;
    logic [3:0]        line_state;
    logic              proto_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    msi_line_ctrl #(.NODE_W(NODE_W), .MAX_SHARERS(15)) u_msi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_op(core_op), .core_ready(core_ready),
        .load_done(load_done), .store_done(store_done),
        .dir_req_valid(dir_req_valid), .dir_req_type(dir_req_type),
        .fwd_valid(fwd_valid), .fwd_type(fwd_type), .fwd_src(fwd_src), .fwd_ready(fwd_ready),
        .rin_valid(rin_valid), .rin_type(rin_type), .rin_acks(rin_acks),
        .rout_valid(rout_valid), .rout_type(rout_type), .rout_dest(rout_dest),
        .line_state(line_state), .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        core_valid = 0; core_op = 0;
        fwd_valid = 0; fwd_type = 0; fwd_src = 0;
        rin_valid = 0; rin_type = 0; rin_acks = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic core(input logic [1:0] op);
        @(negedge clk); core_valid = 1; core_op = op; step();
    endtask

    task automatic fwd(input logic [1:0] t, input logic [NODE_W-1:0] src);
        @(negedge clk); fwd_valid = 1; fwd_type = t; fwd_src = src; step();
    endtask

    task automatic rsp(input logic [1:0] t, input logic [ACK_W-1:0] a);
        @(negedge clk); rin_valid = 1; rin_type = t; rin_acks = a; step();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12", "reset state", line_state, 0);
        chk("R12", "reset outputs", {load_done, store_done, dir_req_valid, rout_valid, proto_err}, 0);
        chk("R12", "idle core_ready", core_ready, 1);
    endtask

    task automatic t_load_miss();
        core(0);
        chk("R1", "GetS issued", {dir_req_valid, dir_req_type}, 3'b100);
        chk("R1", "IS_D", line_state, 3);
        rsp(0, 2);
        chk("R1", "S after data", line_state, 1);
        chk("R1", "load_done", load_done, 1);
    endtask

    task automatic t_hits_s();
        core(0);
        chk("R5", "hit load_done", load_done, 1);
        chk("R5", "hit no request", dir_req_valid, 0);
        chk("R5", "hit keeps S", line_state, 1);
    endtask

    task automatic t_store_early_ack();
        core(1);
        chk("R2", "GetM issued", {dir_req_valid, dir_req_type}, 3'b101);
        chk("R2", "SM_AD", line_state, 6);
        rsp(2, 0);
        chk("R4", "early ack stays SM_AD", line_state, 6);
        chk("R4", "early ack no done", store_done, 0);
        rsp(0, 2);
        chk("R3", "SM_A after data", line_state, 7);
        chk("R3", "not done yet", store_done, 0);
        @(negedge clk); core_valid = 1; core_op = 2; #1;
        chk("R9", "evict stalled in SM_A", core_ready, 0);
        step();
        chk("R9", "SM_A unchanged", line_state, 7);
        chk("R9", "no request on stall", dir_req_valid, 0);
        rsp(2, 0);
        chk("R3", "M after last ack", line_state, 2);
        chk("R3", "store_done", store_done, 1);
    endtask

    task automatic t_hits_m();
        core(1);
        chk("R5", "store hit done", store_done, 1);
        chk("R5", "store hit no req", dir_req_valid, 0);
        core(0);
        chk("R5", "load hit in M", load_done, 1);
    endtask

    task automatic t_fwd_gets();
        fwd(2, 4'd5);
        chk("R10", "data out", {rout_valid, rout_type}, 2'b10);
        chk("R10", "data dest", rout_dest, 5);
        chk("R10", "M to S", line_state, 1);
    endtask

    task automatic t_inv_s();
        fwd(0, 4'd3);
        chk("R7", "InvAck out", {rout_valid, rout_type}, 2'b11);
        chk("R7", "InvAck dest", rout_dest, 3);
        chk("R7", "S to I", line_state, 0);
    endtask

    task automatic t_store_from_i();
        core(1);
        chk("R2", "GetM from I", {dir_req_valid, dir_req_type}, 3'b101);
        chk("R2", "IM_AD", line_state, 4);
        rsp(0, 0);
        chk("R4", "zero count goes M", line_state, 2);
        chk("R4", "zero count done", store_done, 1);
    endtask

    task automatic t_evict_m();
        core(2);
        chk("R6", "PutM issued", {dir_req_valid, dir_req_type}, 3'b110);
        chk("R6", "MI_A", line_state, 8);
        @(negedge clk); core_valid = 1; core_op = 2; #1;
        chk("R9", "evict stalled in MI_A", core_ready, 0);
        step();
        chk("R9", "MI_A unchanged", line_state, 8);
        fwd(1, 0);
        chk("R6", "PutAck to I", line_state, 0);
        chk("R6", "PutAck no error", proto_err, 0);
    endtask

    task automatic t_inv_smad();
        core(0);
        rsp(1, 0);
        chk("R1", "owner data to S", line_state, 1);
        core(1);
        fwd(0, 4'd7);
        chk("R8", "SM_AD to IM_AD", line_state, 4);
        chk("R8", "InvAck dest", rout_dest, 7);
        chk("R8", "no error", proto_err, 0);
        rsp(0, 1);
        chk("R3", "IM_A", line_state, 5);
        rsp(2, 0);
        chk("R8", "completes in M", line_state, 2);
        chk("R8", "store_done", store_done, 1);
    endtask

    task automatic t_fwd_getm();
        fwd(3, 4'd9);
        chk("R10", "data to GetM requester", {rout_valid, rout_type, rout_dest}, {2'b10, 4'd9});
        chk("R10", "M to I", line_state, 0);
    endtask

    task automatic t_errors();
        rsp(2, 0);
        chk("R11", "InvAck in I flags", proto_err, 1);
        chk("R11", "state kept", line_state, 0);
        chk("R11", "no message", rout_valid, 0);
        fwd(1, 0);
        chk("R11", "PutAck in I flags", proto_err, 1);
        chk("R11", "state kept I", line_state, 0);
    endtask

    task automatic t_evict_stable();
        core(2);
        chk("R9", "evict in I no effect", {line_state, dir_req_valid, proto_err}, 0);
        core(0);
        rsp(0, 0);
        core(2);
        chk("R9", "evict in S silent to I", line_state, 0);
        chk("R9", "evict in S no request", dir_req_valid, 0);
    endtask

    task automatic t_priority();
        core(0);
        rsp(0, 0);
        @(negedge clk);
        fwd_valid = 1; fwd_type = 0; fwd_src = 4'd2;
        core_valid = 1; core_op = 1; #1;
        chk("R12", "core loses to forward", core_ready, 0);
        step();
        chk("R12", "Inv taken", line_state, 0);
        chk("R12", "store not taken", dir_req_valid, 0);
        @(negedge clk);
        rin_valid = 1; rin_type = 2; fwd_valid = 1; fwd_type = 1; #1;
        chk("R12", "forward loses to response", fwd_ready, 0);
        step();
        chk("R12", "response event taken", proto_err, 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_load_miss();
        t_hits_s();
        t_store_early_ack();
        t_hits_m();
        t_fwd_gets();
        t_inv_s();
        t_store_from_i();
        t_evict_m();
        t_inv_smad();
        t_fwd_getm();
        t_errors();
        t_evict_stable();
        t_priority();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule